// File: doc/BRIEF.md
# Reset and Suspend Sequencing Controller

This block decides when a small microcontroller core is held in reset, whether it runs or waits at address zero once reset ends, and when the core and its timer are frozen in a low-power suspend. It merges a power-on input, a reset pushbutton and two warm reset sources (bus reset and watchdog). Each warm source has its own enable strap. Every source is brought into the clock domain through a short synchroniser, and the core reset is stretched for a fixed number of cycles after the last source lets go.

Suspend can be reached in two ways. A cold reset (power-on or pushbutton) leads into suspend when the suspend-after-power-on strap is set. Software can also write a one to the suspend bit. Activity on the bus, an interrupt or any reset brings the core back. A debug run pulse also ends suspend, but only when software requested the suspend. A two-bit cause code tells which path is active, and the suspend bit reads back as one for as long as the block is suspended. All pins are plain level or pulse controls; no stream interface is involved.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: A high level on `por_i` or `button_i` asserts `core_rst_o`. `por_i` acts asynchronously, and `button_i` is visible after its second rising edge. Both count as a cold reset.
- R2: `bus_rst_i` causes a reset only while `bus_rst_en_i` is 1, and `wdog_rst_i` only while `wdog_rst_en_i` is 1. With its enable at 0, a source leaves `core_rst_o` low.
- R3: `button_i`, `bus_rst_i` and `wdog_rst_i` each pass through two flops. `core_rst_o` stays high for exactly HOLD_CYCLES (default 2) cycles after the synchronised sources have all dropped. A 3-cycle pulse on an enabled warm source therefore gives 5 cycles of `core_rst_o`.
- R4: While in reset, `core_halt_o` is loaded with the inverse of `run_on_reset_i`. Outside reset, a `dbg_run_i` pulse clears it, except during a suspend that followed a cold reset.
- R5: When `susp_on_por_i` is 1 and the reset that just ended included a cold source, the block enters suspend with cause 01. A reset made only of warm sources never enters suspend.
- R6: While running and out of reset, `susp_wr_i` with `susp_wdata_i`=1 enters suspend in the next cycle with cause 10. With `susp_wdata_i`=0 the strobe changes nothing.
- R7: `core_clk_en_o` and `timer_clk_en_o` are both 0 while suspended and both 1 otherwise.
- R8: Suspend of either kind ends one cycle after `bus_idle_i`=0 or `irq_i`=1 is sampled. It also ends when any reset is asserted.
- R9: `dbg_run_i` ends a software-entered suspend (cause 10). It is ignored in a suspend after a cold reset (cause 01).
- R10: `susp_cause_o` is 00 when not suspended, 01 for a cold-reset suspend and 10 for a software suspend. `susp_bit_o` is 1 exactly while suspended, so it clears by itself on wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| button_i | input | 1 | Reset pushbutton, active high, cold reset |
| bus_rst_i | input | 1 | Bus reset request, active high |
| wdog_rst_i | input | 1 | Watchdog reset request, active high |
| bus_rst_en_i | input | 1 | Strap: take bus reset |
| wdog_rst_en_i | input | 1 | Strap: take watchdog reset |
| run_on_reset_i | input | 1 | Strap: 1 run from address zero, 0 halt there |
| susp_on_por_i | input | 1 | Strap: suspend after a cold reset |
| susp_wr_i | input | 1 | Write strobe for the suspend bit |
| susp_wdata_i | input | 1 | Value written to the suspend bit |
| bus_idle_i | input | 1 | 1 while the bus input is idle |
| irq_i | input | 1 | Interrupt request |
| dbg_run_i | input | 1 | Debug run pulse |
| core_rst_o | output | 1 | Reset to program counter and registers |
| core_halt_o | output | 1 | Hold core at address zero |
| core_clk_en_o | output | 1 | Core clock enable |
| timer_clk_en_o | output | 1 | Timer clock enable |
| susp_cause_o | output | 2 | Suspend cause code |
| susp_bit_o | output | 1 | Suspend bit read-back |

## Verification
The assertions assume that `bus_idle_i`, `irq_i`, `dbg_run_i` and the write strobe are already synchronous to `clk_i`. They also assume the straps hold steady while a reset is in progress. The stimulus changes inputs only half a cycle after a rising edge, gives strobes and run pulses one cycle each, and alters straps only between scenarios while the block sits idle out of reset. Only `por_i` is asserted asynchronously, and it serves as the reset that disables every property.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN       = 2'b00,
    ST_SUSP_COLD = 2'b01,
    ST_SUSP_SW   = 2'b10
  } susp_state_e;

  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_COLD = 2'b01;
  localparam logic [1:0] CAUSE_SW   = 2'b10;

endpackage

// File: rtl/pws_sync.sv
module pws_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             arst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pws_reset_gen.sv
module pws_reset_gen #(
  parameter int NUM_WARM    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 2
) (
  input  logic                clk_i,
  input  logic                por_i,
  input  logic                btn_i,
  input  logic [NUM_WARM-1:0] warm_i,
  input  logic [NUM_WARM-1:0] warm_en_i,
  output logic                rst_o,
  output logic                cold_done_o
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam int SRC_W = NUM_WARM + 1;

  logic [SYNC_STAGES-1:0] por_chain_q;
  logic [SRC_W-1:0]       src_s;
  logic [NUM_WARM-1:0]    warm_gated;
  logic                   cold_src, any_src, done;
  logic [CNT_W-1:0]       cnt_q;
  logic                   cold_seen_q;

  // power-on: asynchronous assert, synchronous release
  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) por_chain_q <= '1;
    else       por_chain_q <= {por_chain_q[SYNC_STAGES-2:0], 1'b0};
  end

  pws_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) u_src_sync (
    .clk_i  (clk_i),
    .arst_i (por_i),
    .d_i    ({warm_i, btn_i}),
    .q_o    (src_s)
  );

  for (genvar g = 0; g < NUM_WARM; g++) begin : g_gate
    assign warm_gated[g] = src_s[g+1] & warm_en_i[g];
  end

  assign cold_src = por_chain_q[SYNC_STAGES-1] | src_s[0];
  assign any_src  = cold_src | (|warm_gated);
  assign done     = !any_src && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      cnt_q       <= CNT_W'(HOLD_CYCLES);
      cold_seen_q <= 1'b1;
    end else begin
      if (any_src)             cnt_q <= CNT_W'(HOLD_CYCLES);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
      if (cold_src)            cold_seen_q <= 1'b1;
      else if (done)           cold_seen_q <= 1'b0;
    end
  end

  assign rst_o       = any_src || (cnt_q != '0);
  assign cold_done_o = done && cold_seen_q;

  // R3: a live source keeps reset asserted in the next cycle
  p_src_holds_r3: assert property (@(posedge clk_i) disable iff (por_i)
    any_src |=> rst_o);

  // R3: reset only falls after the sources have been quiet for two cycles
  p_release_r3: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(rst_o) |-> (!$past(any_src) && !$past(any_src, 2)));

endmodule

// File: rtl/pws_suspend.sv
module pws_suspend
  import pwr_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       arst_i,
  input  logic       rst_i,
  input  logic       cold_done_i,
  input  logic       cfg_run_on_reset_i,
  input  logic       cfg_susp_on_por_i,
  input  logic       susp_wr_i,
  input  logic       susp_wdata_i,
  input  logic       bus_idle_i,
  input  logic       irq_i,
  input  logic       dbg_run_i,
  output logic       halt_o,
  output logic       suspended_o,
  output logic [1:0] cause_o
);

  susp_state_e state_q, state_d;
  logic        halt_q;
  logic        wake_evt;

  assign wake_evt = !bus_idle_i || irq_i;

  always_comb begin
    state_d = state_q;
    if (cold_done_i && cfg_susp_on_por_i) begin
      state_d = ST_SUSP_COLD;
    end else if (rst_i) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN:       if (susp_wr_i && susp_wdata_i) state_d = ST_SUSP_SW;
        ST_SUSP_COLD: if (wake_evt)                  state_d = ST_RUN;
        ST_SUSP_SW:   if (wake_evt || dbg_run_i)     state_d = ST_RUN;
        default:                                     state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      state_q <= ST_RUN;
      halt_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (rst_i)                                     halt_q <= !cfg_run_on_reset_i;
      else if (dbg_run_i && state_q != ST_SUSP_COLD) halt_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_SUSP_COLD: cause_o = CAUSE_COLD;
      ST_SUSP_SW:   cause_o = CAUSE_SW;
      default:      cause_o = CAUSE_NONE;
    endcase
  end

  assign suspended_o = (state_q != ST_RUN);
  assign halt_o      = halt_q;

  p_enter_sw_r6: assert property (@(posedge clk_i) disable iff (arst_i)
    (state_q == ST_RUN && !rst_i && susp_wr_i && susp_wdata_i) |=> (state_q == ST_SUSP_SW));

  p_wake_r8: assert property (@(posedge clk_i) disable iff (arst_i)
    (state_q != ST_RUN && !rst_i && wake_evt) |=> (state_q == ST_RUN));

  p_run_ignored_r9: assert property (@(posedge clk_i) disable iff (arst_i)
    (state_q == ST_SUSP_COLD && !rst_i && !wake_evt) |=> (state_q == ST_SUSP_COLD));

  p_run_wakes_r9: assert property (@(posedge clk_i) disable iff (arst_i)
    (state_q == ST_SUSP_SW && !rst_i && dbg_run_i) |=> (state_q == ST_RUN));

  p_halt_load_r4: assert property (@(posedge clk_i) disable iff (arst_i)
    rst_i |=> (halt_q == !$past(cfg_run_on_reset_i)));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 2
) (
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       button_i,
  input  logic       bus_rst_i,
  input  logic       wdog_rst_i,
  input  logic       bus_rst_en_i,
  input  logic       wdog_rst_en_i,
  input  logic       run_on_reset_i,
  input  logic       susp_on_por_i,
  input  logic       susp_wr_i,
  input  logic       susp_wdata_i,
  input  logic       bus_idle_i,
  input  logic       irq_i,
  input  logic       dbg_run_i,
  output logic       core_rst_o,
  output logic       core_halt_o,
  output logic       core_clk_en_o,
  output logic       timer_clk_en_o,
  output logic [1:0] susp_cause_o,
  output logic       susp_bit_o
);

  localparam int NUM_WARM = 2;

  logic core_rst, cold_done, suspended;

  pws_reset_gen #(
    .NUM_WARM    (NUM_WARM),
    .SYNC_STAGES (SYNC_STAGES),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_rst (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .btn_i       (button_i),
    .warm_i      ({wdog_rst_i, bus_rst_i}),
    .warm_en_i   ({wdog_rst_en_i, bus_rst_en_i}),
    .rst_o       (core_rst),
    .cold_done_o (cold_done)
  );

  pws_suspend u_susp (
    .clk_i              (clk_i),
    .arst_i             (por_i),
    .rst_i              (core_rst),
    .cold_done_i        (cold_done),
    .cfg_run_on_reset_i (run_on_reset_i),
    .cfg_susp_on_por_i  (susp_on_por_i),
    .susp_wr_i          (susp_wr_i),
    .susp_wdata_i       (susp_wdata_i),
    .bus_idle_i         (bus_idle_i),
    .irq_i              (irq_i),
    .dbg_run_i          (dbg_run_i),
    .halt_o             (core_halt_o),
    .suspended_o        (suspended),
    .cause_o            (susp_cause_o)
  );

  assign core_rst_o     = core_rst;
  assign core_clk_en_o  = !suspended;
  assign timer_clk_en_o = !suspended;
  assign susp_bit_o     = suspended;

  // R7: both enables follow the suspend bit one-for-one
  p_gate_r7: assert property (@(posedge clk_i) disable iff (por_i)
    susp_bit_o |-> (!core_clk_en_o && !timer_clk_en_o));

endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;

  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic por = 1'b0, button = 1'b0, bus_rst = 1'b0, wdog_rst = 1'b0;
  logic bus_en = 1'b0, wd_en = 1'b0, run_cfg = 1'b0, spor_cfg = 1'b0;
  logic wr = 1'b0, wdata = 1'b0, idle = 1'b1, irq = 1'b0, run = 1'b0;
  logic core_rst, halt, cen, ten, sbit;
  logic [1:0] cause;

  int errors = 0, checks = 0;
  bit cmp_on = 1'b0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  pwr_seq_ctrl i_pwr_seq_ctrl (
    .clk_i(clk), .por_i(por), .button_i(button), .bus_rst_i(bus_rst),
    .wdog_rst_i(wdog_rst), .bus_rst_en_i(bus_en), .wdog_rst_en_i(wd_en),
    .run_on_reset_i(run_cfg), .susp_on_por_i(spor_cfg), .susp_wr_i(wr),
    .susp_wdata_i(wdata), .bus_idle_i(idle), .irq_i(irq), .dbg_run_i(run),
    .core_rst_o(core_rst), .core_halt_o(halt), .core_clk_en_o(cen),
    .timer_clk_en_o(ten), .susp_cause_o(cause), .susp_bit_o(sbit)
  );

  // behavioural reference: pipelines of source samples, a countdown and a mode number
  bit m_por_a, m_por_b;
  bit [2:0] m_a, m_b;   // bit0 button, bit1 bus, bit2 watchdog
  int m_cnt, m_mode;    // mode 0 running, 1 cold suspend, 2 software suspend
  bit m_cold, m_halt;

  function automatic bit m_src();
    return m_por_b | m_b[0] | (m_b[1] & bus_en) | (m_b[2] & wd_en);
  endfunction
  function automatic bit m_rst();
    return m_src() || (m_cnt != 0);
  endfunction

  always @(posedge clk) begin
    if (por) begin
      m_por_a = 1; m_por_b = 1; m_a = 0; m_b = 0;
      m_cnt = HOLD; m_cold = 1; m_mode = 0; m_halt = 1;
      cmp_on = 1'b1;
    end else begin
      bit src, csrc, rst, fin;
      int nmode;
      src = m_src(); csrc = m_por_b | m_b[0]; rst = m_rst();
      fin = !src && m_cnt == 1;
      nmode = m_mode;
      if (fin && m_cold && spor_cfg) nmode = 1;
      else if (rst) nmode = 0;
      else if (m_mode == 0 && wr && wdata) nmode = 2;
      else if (m_mode != 0 && (!idle || irq)) nmode = 0;
      else if (m_mode == 2 && run) nmode = 0;
      if (rst) m_halt = !run_cfg;
      else if (run && m_mode != 1) m_halt = 0;
      if (csrc) m_cold = 1; else if (fin) m_cold = 0;
      m_cnt = src ? HOLD : (m_cnt > 0 ? m_cnt - 1 : 0);
      m_mode = nmode;
      m_por_b = m_por_a; m_por_a = 0;
      m_b = m_a; m_a = {wdog_rst, bus_rst, button};
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done_flag) begin
      chk("R1/R2/R3 core_rst", core_rst, m_rst());
      chk("R4 halt", halt, m_halt);
      chk("R7 core_clk_en", cen, m_mode == 0);
      chk("R7 timer_clk_en", ten, m_mode == 0);
      chk("R10 cause", cause, m_mode);
      chk("R10 susp_bit", sbit, m_mode != 0);
    end
  end

  task automatic drv();
    @(negedge clk); #1;
  endtask
  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) drv();
  endtask
  task automatic pulse_run();
    run = 1; drv(); run = 0;
  endtask
  task automatic sw_susp();
    wr = 1; wdata = 1; drv(); wr = 0; wdata = 0;
  endtask
  // pulse a warm source 3 cycles and count reset cycles seen
  task automatic warm_pulse(input bit use_wd, output int seen);
    seen = 0;
    if (use_wd) wdog_rst = 1; else bus_rst = 1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); seen += core_rst; #1; end
    wdog_rst = 0; bus_rst = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); seen += core_rst; #1; end
  endtask

  task automatic summary();
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    int seen;
    drv();
    por = 1; wait_n(3);
    chk("R1 reset state rst", core_rst, 1);
    chk("R4 reset state halt", halt, 1);
    chk("R10 reset state cause", cause, 0);
    por = 0; wait_n(6);
    chk("R3 released", core_rst, 0);
    chk("R4 halted run_on_reset=0", halt, 1);
    pulse_run(); wait_n(1);
    chk("R4 run clears halt", halt, 0);

    // masked warm sources
    warm_pulse(0, seen); chk("R2 bus reset masked", seen, 0);
    warm_pulse(1, seen); chk("R2 watchdog masked", seen, 0);
    run_cfg = 1; bus_en = 1;
    warm_pulse(0, seen); chk("R3 bus reset length", seen, 5);
    chk("R4 run_on_reset=1 not halted", halt, 0);
    wd_en = 1; run_cfg = 0;
    warm_pulse(1, seen); chk("R3 watchdog reset length", seen, 5);
    chk("R4 halted after warm reset", halt, 1);
    pulse_run(); run_cfg = 1;

    // software suspend
    wr = 1; wdata = 0; drv(); wr = 0; wait_n(1);
    chk("R6 write 0 ignored", sbit, 0);
    sw_susp(); wait_n(1);
    chk("R6 suspended", sbit, 1);
    chk("R10 cause sw", cause, 2);
    chk("R7 core clk off", cen, 0);
    pulse_run(); wait_n(1);
    chk("R9 run wakes sw suspend", sbit, 0);
    sw_susp(); irq = 1; drv(); irq = 0; wait_n(1);
    chk("R8 irq wakes", sbit, 0);
    sw_susp(); idle = 0; drv(); idle = 1; wait_n(1);
    chk("R8 bus activity wakes", sbit, 0);
    sw_susp(); bus_rst = 1; drv(); bus_rst = 0; wait_n(8);
    chk("R8 reset wakes", sbit, 0);

    // cold suspend via pushbutton
    spor_cfg = 1;
    button = 1; wait_n(2); button = 0; wait_n(8);
    chk("R5 button leads to suspend", cause, 1);
    pulse_run(); wait_n(2);
    chk("R9 run ignored in cold suspend", sbit, 1);
    irq = 1; drv(); irq = 0; wait_n(1);
    chk("R8 irq wakes cold suspend", sbit, 0);
    warm_pulse(1, seen); wait_n(2);
    chk("R5 warm reset no suspend", sbit, 0);
    por = 1; wait_n(2); por = 0; wait_n(8);
    chk("R5 power-on leads to suspend", cause, 1);
    chk("R7 timer clk off", ten, 0);
    idle = 0; drv(); idle = 1; wait_n(2);
    chk("R10 cause cleared on wake", cause, 0);
    summary();
  end

endmodule